// File: doc/BRIEF.md
# Push-Button Edge-Capture Port with Interrupt

This block turns four push-button lines into a memory-mapped input port that a processor can poll or take interrupts from. Every line first passes through a two-flop synchronizer. An optional debounce filter follows. The filtered level can be read back. In edge mode, each selected transition of a line sets a sticky capture bit. The capture bits are gated by a per-bit mask and ORed into one interrupt request.

The capture polarity is chosen at build time: rising edges, falling edges, or no capture at all. With no capture, the interrupt follows the masked filtered level. It stays high for as long as any enabled input is active (high). Software services an edge interrupt by writing ones to the capture register to clear the matching bits. The debounce filter accepts a new level only after the synchronized input has held it for a parameterized number of clock cycles. As a result, switch bounce cannot set a capture bit again just after it was cleared.

Register map (byte offsets): 0x0 filtered input level, read-only; 0x4 reads zero; 0x8 interrupt mask, read/write; 0xC edge capture, read, write-one-to-clear. Bits above the port width read as zero.

Top module: `btn_irq_port`

## Requirements
- R1: After reset, the mask and capture registers read zero and irq_o is low.
- R2: A read at offset 0x0 returns the filtered level of the inputs in bits [3:0]. A read at 0x4 returns zero. Writes to 0x0 have no effect on any register.
- R3: Offset 0x8 holds a 4-bit mask that is written from wr_data_i[3:0] and read back in bits [3:0], with all upper read bits zero.
- R4: In rising mode, a 0-to-1 change of a filtered line sets its capture bit (offset 0xC, bit n for line n). The bit then stays set until it is cleared.
- R5: In falling mode, a 1-to-0 change of a filtered line sets its capture bit. The bit stays set until it is cleared.
- R6: A write to 0xC clears each capture bit whose wr_data_i bit is 1 and leaves the other bits unchanged. Writing 0xF clears all four.
- R7: When a capture edge and a clear write hit the same bit in the same cycle, the bit stays set.
- R8: In edge modes, irq_o is high exactly when some capture bit and its mask bit are both 1.
- R9: In level mode, offset 0xC reads zero and clear writes have no effect. irq_o is high while any filtered line that has its mask bit set is 1.
- R10: With a debounce depth of D cycles, a synchronized pulse shorter than D cycles changes neither the data register nor the capture register. A level held longer than D cycles is accepted.
- R11: rd_data_o is zero whenever rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | WIDTH (4) | Raw asynchronous button lines |
| addr_i | input | ADDR_W (4) | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W (32) | Read data, combinational, zero when idle |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the collision of an edge with a clear write in the same cycle. A design that let the clear win would silently drop a button press and never raise its interrupt. A 2-cycle glitch is applied to a debounced port and to an undebounced port side by side. A filter with a wrong threshold would capture the glitch; a missing synchronizer stage would shift the capture cycle. Level mode is checked by writing clears while the input stays active; a design that kept a capture register there would drop the request after the clear. Random patterns with random masks and partial clears check that the bits are sticky and that one bit's clear does not touch its neighbours.

// File: rtl/btn_port_pkg.sv
package btn_port_pkg;
  typedef enum logic [1:0] {
    CAP_RISE = 2'd0,
    CAP_FALL = 2'd1,
    CAP_NONE = 2'd2
  } cap_mode_e;

  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_GAP  = 4;
  localparam int unsigned OFS_MASK = 8;
  localparam int unsigned OFS_CAP  = 12;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned CYCLES = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] lvl_o
);
  generate
    if (CYCLES == 0) begin : g_bypass
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign lvl_o = lvl_i;
    end else begin : g_filter
      localparam int unsigned CW = $clog2(CYCLES + 1);
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
      for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic [CW-1:0] cnt_q;
        logic          filt_q;
        // accept the new level once it has differed for CYCLES clocks in a row
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
          end else if (lvl_i[gi] == filt_q) begin
            cnt_q <= '0;
          end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            filt_q <= lvl_i[gi];
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        assign lvl_o[gi] = filt_q;
      end
    end
  endgenerate
endmodule

// File: rtl/btn_edge_cap.sv
module btn_edge_cap
  import btn_port_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter cap_mode_e   MODE  = CAP_RISE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] cap_o,
  output logic             irq_o
);
  generate
    if (MODE == CAP_NONE) begin : g_level
      logic unused_in;
      assign unused_in = clk_i ^ rst_ni ^ (^clr_i);
      assign cap_o = '0;
      assign irq_o = |(lvl_i & mask_i);
    end else begin : g_edge
      logic [WIDTH-1:0] prev_q, cap_q, hit;
      if (MODE == CAP_RISE) begin : g_rise
        assign hit = lvl_i & ~prev_q;
      end else begin : g_fall
        assign hit = ~lvl_i & prev_q;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= '0;
          cap_q  <= '0;
        end else begin
          prev_q <= lvl_i;
          cap_q  <= (cap_q & ~clr_i) | hit;  // new edge beats a clear
        end
      end
      assign cap_o = cap_q;
      assign irq_o = |(cap_q & mask_i);
    end
  endgenerate
endmodule

// File: rtl/btn_regs.sv
module btn_regs
  import btn_port_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [WIDTH-1:0]  lvl_i,
  input  logic [WIDTH-1:0]  cap_i,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  clr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(OFS_CAP);

  logic [WIDTH-1:0] mask_q;
  logic             unused_wdata;
  assign unused_wdata = ^wr_data_i[DATA_W-1:WIDTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         mask_q <= '0;
    else if (wr_en_i && addr_i == A_MASK) mask_q <= wr_data_i[WIDTH-1:0];
  end

  assign clr_o  = (wr_en_i && addr_i == A_CAP) ? wr_data_i[WIDTH-1:0] : '0;
  assign mask_o = mask_q;

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_DATA:  rd_data_o[WIDTH-1:0] = lvl_i;
        A_MASK:  rd_data_o[WIDTH-1:0] = mask_q;
        A_CAP:   rd_data_o[WIDTH-1:0] = cap_i;
        default: rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/btn_irq_port.sv
module btn_irq_port
  import btn_port_pkg::*;
#(
  parameter int unsigned WIDTH           = 4,
  parameter int unsigned ADDR_W          = 4,
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE_CYCLES = 0,
  parameter cap_mode_e   CAPTURE_MODE    = CAP_RISE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  btn_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] sync_lvl, filt_lvl, mask_q, cap_q, clr_bits;

  btn_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_i), .q_o(sync_lvl)
  );

  btn_debounce #(.WIDTH(WIDTH), .CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_lvl), .lvl_o(filt_lvl)
  );

  btn_edge_cap #(.WIDTH(WIDTH), .MODE(CAPTURE_MODE)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(filt_lvl), .mask_i(mask_q),
    .clr_i(clr_bits), .cap_o(cap_q), .irq_o(irq_o)
  );

  btn_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .lvl_i(filt_lvl), .cap_i(cap_q),
    .mask_o(mask_q), .clr_o(clr_bits), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/btn_irq_port_chk.sv
module btn_irq_port_chk
  import btn_port_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEB    = 0,
  parameter cap_mode_e   MODE   = CAP_RISE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_o,
  input logic [WIDTH-1:0]  sync_lvl,
  input logic [WIDTH-1:0]  filt_lvl,
  input logic [WIDTH-1:0]  mask_q,
  input logic [WIDTH-1:0]  cap_q
);
  logic [WIDTH-1:0] clr_req;
  assign clr_req = (wr_en_i && addr_i == ADDR_W'(OFS_CAP)) ? wr_data_i[WIDTH-1:0] : '0;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rd_data_o == '0);  // R11

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);  // R8

  AST_CAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q != '0) |=> ((($past(cap_q) & ~$past(clr_req)) & ~cap_q) == '0));  // R6

  generate
    if (MODE == CAP_RISE) begin : g_rise
      AST_CAP_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cap_q & ~$past(cap_q)) & ~($past(filt_lvl) & ~$past(filt_lvl, 2))) == '0);  // R4
    end else if (MODE == CAP_FALL) begin : g_fall
      AST_CAP_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cap_q & ~$past(cap_q)) & ~(~$past(filt_lvl) & $past(filt_lvl, 2))) == '0);  // R5
    end else begin : g_lvl
      AST_LVL_IRQ_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (filt_lvl != '0));  // R9
    end
    if (DEB > 0) begin : g_deb
      AST_FILT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_lvl != $past(filt_lvl)) |-> ($past(sync_lvl) != $past(filt_lvl)));  // R10
    end
  endgenerate
endmodule

bind btn_irq_port btn_irq_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .DEB(DEBOUNCE_CYCLES), .MODE(CAPTURE_MODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
  .sync_lvl(sync_lvl), .filt_lvl(filt_lvl), .mask_q(mask_q), .cap_q(cap_q)
);

// File: tb/tb_btn_irq_port.sv
module tb_btn_irq_port;
  import btn_port_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 12;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  btn = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_r, rd_f, rd_l;
  logic        irq_r, irq_f, irq_l;
  int total = 0, bad = 0;
  logic [31:0] v_r, v_f, v_l;
  logic [3:0]  m_cap_r, m_cap_f, m_mask, m_pat;

  always #(CLK_PERIOD/2) clk = ~clk;

  // rising, debounce 4
  btn_irq_port #(.DEBOUNCE_CYCLES(4), .CAPTURE_MODE(CAP_RISE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_r), .irq_o(irq_r));
  btn_irq_port #(.DEBOUNCE_CYCLES(0), .CAPTURE_MODE(CAP_FALL)) dut_f (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_f), .irq_o(irq_f));
  btn_irq_port #(.DEBOUNCE_CYCLES(0), .CAPTURE_MODE(CAP_NONE)) dut_l (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_l), .irq_o(irq_l));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(logic [3:0] a);
    @(negedge clk); addr = a; rd_en = 1;
    #1; v_r = rd_r; v_f = rd_f; v_l = rd_l;
    rd_en = 0;
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] rise_of(logic [3:0] o, logic [3:0] n);
    return n & ~o;
  endfunction
  function automatic logic [3:0] fall_of(logic [3:0] o, logic [3:0] n);
    return o & ~n;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    hold(3); rst_n = 1; hold(2);

    // R1 reset state
    bus_rd(4'h8); check("R1 mask r", v_r, 0); check("R1 mask f", v_f, 0); check("R1 mask l", v_l, 0);
    bus_rd(4'hC); check("R1 cap r", v_r, 0); check("R1 cap f", v_f, 0);
    check("R1 irq", {irq_r, irq_f, irq_l}, 0);

    // R11 idle read
    @(negedge clk); addr = 4'h8; rd_en = 0; #1;
    check("R11 idle", rd_r | rd_f | rd_l, 0);

    // R2 gap offset and write to data ignored
    btn = 4'h5; hold(HOLD);
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0); check("R2 data r", v_r, 5); check("R2 data l", v_l, 5);
    bus_rd(4'h4); check("R2 gap", v_r | v_f | v_l, 0);
    bus_rd(4'h8); check("R2 mask untouched", v_r, 0);
    bus_rd(4'hC); check("R4 cap r", v_r, 5); check("R2 cap f", v_f, 0);

    // R3 mask upper bits dropped
    bus_wr(4'h8, 32'hABCD_EF0F);
    bus_rd(4'h8); check("R3 mask", v_r, 32'hF);
    hold(1); check("R8 irq r", irq_r, 1); check("R9 irq l", irq_l, 1); check("R8 irq f", irq_f, 0);

    // R6 partial clear, R9 level mode ignores clear
    bus_wr(4'hC, 32'h1);
    bus_rd(4'hC); check("R6 partial", v_r, 4); check("R9 cap l", v_l, 0);
    bus_wr(4'hC, 32'hF);
    bus_rd(4'hC); check("R6 all", v_r, 0);
    hold(1); check("R8 irq clr", irq_r, 0); check("R9 irq still", irq_l, 1);
    btn = 4'h0; hold(HOLD);
    hold(1); check("R9 irq drop", irq_l, 0);
    bus_rd(4'hC); check("R5 cap f", v_f, 5);
    bus_wr(4'hC, 32'hF);

    // R10 glitch: 2-cycle pulse
    @(negedge clk); btn = 4'h1; hold(2); btn = 4'h0; hold(HOLD);
    bus_rd(4'h0); check("R10 data r", v_r, 0);
    bus_rd(4'hC); check("R10 cap r", v_r, 0); check("R10 undebounced f", v_f, 1);
    bus_wr(4'hC, 32'hF);

    // R7 edge and clear same cycle (dut_f: 2 sync stages then capture)
    btn = 4'h2; hold(HOLD); bus_wr(4'hC, 32'hF);
    @(negedge clk); btn = 4'h0;
    @(negedge clk);
    @(negedge clk); addr = 4'hC; wr_data = 32'hF; wr_en = 1;
    @(negedge clk); wr_en = 0;
    bus_rd(4'hC); check("R7 collide", v_f, 2);
    hold(HOLD); bus_wr(4'hC, 32'hF);

    // random phase
    m_pat = 0; m_cap_r = 0; m_cap_f = 0; m_mask = 4'hF;
    for (int it = 0; it < 60; it++) begin
      logic [3:0] np;
      np = 4'($urandom);
      btn = np; hold(HOLD);
      m_cap_r |= rise_of(m_pat, np);
      m_cap_f |= fall_of(m_pat, np);
      m_pat = np;
      if ($urandom % 3 == 0) begin
        logic [31:0] mw;
        mw = $urandom; bus_wr(4'h8, mw); m_mask = mw[3:0];
      end
      if ($urandom % 2 == 0) begin
        logic [31:0] cw;
        cw = $urandom; bus_wr(4'hC, cw);
        m_cap_r &= ~cw[3:0]; m_cap_f &= ~cw[3:0];
      end
      bus_rd(4'h0); check("R2 rnd data", v_r, {28'd0, m_pat});
      bus_rd(4'h8); check("R3 rnd mask", v_f, {28'd0, m_mask});
      bus_rd(4'hC);
      check("R4 rnd cap", v_r, {28'd0, m_cap_r});
      check("R5 rnd cap", v_f, {28'd0, m_cap_f});
      check("R9 rnd cap", v_l, 0);
      hold(1);
      check("R8 rnd irq r", irq_r, |(m_cap_r & m_mask));
      check("R8 rnd irq f", irq_f, |(m_cap_f & m_mask));
      check("R9 rnd irq l", irq_l, |(m_pat & m_mask));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule